// File: doc/BRIEF.md
# Two-Wire Slave Register Port

This block is a serial slave on a two-wire bus (clock plus open-drain data). It gives an external bus master read and write access to a private file of 256 eight-bit registers. The 7-bit device address has its top two bits tied to zero. The low five bits come from strap inputs, which are captured while reset is held and frozen when reset is released.

After a write-direction address, the first data byte following a STOP (or reset) sets an internal register pointer. Every further write byte lands at the pointer, and the pointer then steps by one. A read-direction address streams bytes out from the pointer, and the pointer also steps after each byte. STOP returns the pointer to zero. A START or repeated START leaves the pointer alone. This lets a master point at a register with a short write and then read from that point straight away. The master drives both lines. The block only pulls data low through `sda_oe`, and never holds the clock.

Top module: `i2cs_slave`

## Requirements
- R1: The device address is {2'b00, strap_addr}, where strap_addr is the value present during the last reset cycle. Changes to strap_addr after reset is released have no effect.
- R2: When the seven address bits match, the block drives data low on the ninth clock. When they do not match, it drives nothing and ignores every byte until the next START.
- R3: An address-byte LSB of 0 selects a master write (the block receives), and 1 selects a master read (the block transmits).
- R4: The first byte written after a STOP or reset loads the pointer and is not stored. Later written bytes are stored at the pointer.
- R5: The pointer increments by one after each data byte, written or read, and wraps from 0xFF to 0x00.
- R6: STOP sets the pointer to 0x00, so a read that follows a STOP returns register 0x00 first.
- R7: START and repeated START keep the pointer. A write followed by a repeated-START read returns data from the pointer that was set. A write after a repeated START stores its first byte at the current pointer, with no pointer byte.
- R8: Bytes are shifted most significant bit first in both directions.
- R9: The block acknowledges every received data byte of a matched write.
- R10: After a master NACK on a read byte, the block releases data and drives nothing until the next START or STOP. Data is also released on STOP and after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples both bus lines |
| rst | input | 1 | Synchronous active-high reset. Straps are sampled while it is high |
| strap_addr | input | 5 | Low five bits of the device address |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |

## Verification
A repeated START can arrive in the cycle right after the pointer has been loaded or advanced. Pointer retention and pointer update therefore meet on the same bus boundary. The bench provokes this by issuing a pointer write and, with no STOP, a repeated START followed by either a read or a further write. It judges the result by the bytes that come back and by where the extra write byte lands. A STOP that follows a pointer increment is the second case. It is judged by a read after the STOP that must return register 0x00, including when the increment has just wrapped from 0xFF.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  localparam int DEV_ADDR_W = 7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_RX,
    ST_RACK,
    ST_TX,
    ST_TACK,
    ST_TNEXT
  } slv_state_t;
endpackage

// File: rtl/i2cs_sync_edge.sv
module i2cs_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q, scl_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_ff[STAGES-1];
      sda_q  <= sda_ff[STAGES-1];
    end
  end

  assign scl_s     = scl_ff[STAGES-1];
  assign sda_s     = sda_ff[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2cs_regfile.sv
module i2cs_regfile #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/i2cs_slave.sv
module i2cs_slave
  import i2cs_pkg::*;
#(
  parameter int STRAP_W     = 5,
  parameter int SYNC_STAGES = 2,
  parameter int AW          = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [STRAP_W-1:0] strap_addr,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe
);
  localparam int DW    = 8;
  localparam int FIX_W = DEV_ADDR_W - STRAP_W;

  logic [DEV_ADDR_W-1:0] dev_addr;
  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  slv_state_t state;
  logic [3:0]    bitcnt;
  logic [DW-1:0] shreg;
  logic [AW-1:0] ptr;
  logic          ptr_pending;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic [DW-1:0] rdata;

  i2cs_sync_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2cs_regfile #(.AW(AW), .DW(DW)) u_regs (
    .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
    .raddr(ptr), .rdata(rdata)
  );

  // straps follow the pins while reset is high, freeze on release
  always_ff @(posedge clk) begin
    if (rst) dev_addr <= {{FIX_W{1'b0}}, strap_addr};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      bitcnt      <= '0;
      shreg       <= '0;
      ptr         <= '0;
      ptr_pending <= 1'b1;
      sda_oe      <= 1'b0;
      wr_en       <= 1'b0;
      wr_addr     <= '0;
      wr_data     <= '0;
    end else begin
      wr_en <= 1'b0;
      if (stop_det) begin
        state       <= ST_IDLE;
        ptr         <= '0;
        ptr_pending <= 1'b1;
        sda_oe      <= 1'b0;
      end else if (start_det) begin
        state  <= ST_ADDR;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else begin
        unique case (state)
          ST_IDLE: ;
          ST_ADDR: begin
            if (scl_rise) begin
              shreg  <= {shreg[DW-2:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              if (shreg[DW-1:1] == dev_addr) begin
                state  <= ST_AACK;
                sda_oe <= 1'b1;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          ST_AACK: begin
            if (scl_fall) begin
              bitcnt <= '0;
              if (shreg[0]) begin
                shreg  <= rdata;
                sda_oe <= ~rdata[DW-1];
                ptr    <= ptr + 1'b1;
                state  <= ST_TX;
              end else begin
                sda_oe <= 1'b0;
                state  <= ST_RX;
              end
            end
          end
          ST_RX: begin
            if (scl_rise) begin
              shreg  <= {shreg[DW-2:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              if (ptr_pending) begin
                ptr         <= shreg;
                ptr_pending <= 1'b0;
              end else begin
                wr_en   <= 1'b1;
                wr_addr <= ptr;
                wr_data <= shreg;
                ptr     <= ptr + 1'b1;
              end
              sda_oe <= 1'b1;
              state  <= ST_RACK;
            end
          end
          ST_RACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              bitcnt <= '0;
              state  <= ST_RX;
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (bitcnt == 4'd7) begin
                sda_oe <= 1'b0;
                state  <= ST_TACK;
              end else begin
                shreg  <= {shreg[DW-2:0], 1'b0};
                sda_oe <= ~shreg[DW-2];
                bitcnt <= bitcnt + 4'd1;
              end
            end
          end
          ST_TACK: begin
            if (scl_rise) state <= sda_s ? ST_IDLE : ST_TNEXT;
          end
          ST_TNEXT: begin
            if (scl_fall) begin
              shreg  <= rdata;
              sda_oe <= ~rdata[DW-1];
              ptr    <= ptr + 1'b1;
              bitcnt <= '0;
              state  <= ST_TX;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  p_strap_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(dev_addr));
  p_oe_phase_r2: assert property (@(posedge clk) disable iff (rst)
    sda_oe |-> (state == ST_AACK || state == ST_RACK || state == ST_TX));
  p_stop_clears_r6: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> (ptr == '0));
  p_start_keeps_r7: assert property (@(posedge clk) disable iff (rst)
    start_det |=> $stable(ptr));
  p_stop_release_r10: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !sda_oe);
  p_nack_release_r10: assert property (@(posedge clk) disable iff (rst)
    (state == ST_TACK && scl_rise && sda_s) |=> !sda_oe);
endmodule

// File: tb/tb_i2cs_slave.sv
module tb_i2cs_slave;
  localparam int Q = 10;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [4:0] strap = 5'b10110;
  logic scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_oe;
  logic sda_line;
  int total = 0, fails = 0;
  bit finished = 1'b0;

  localparam logic [6:0] DEV = 7'h16;

  always #10 clk = ~clk;
  assign sda_line = m_sda & ~sda_oe;

  i2cs_slave dut (
    .clk(clk), .rst(rst), .strap_addr(strap),
    .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wq();
    scl = 1'b1;   wq();
    m_sda = 1'b0; wq();
    scl = 1'b0;   wq();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wq();
    scl = 1'b1;   wq();
    m_sda = 1'b1; wq();
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; wq();
      scl = 1'b1;   wq();
      scl = 1'b0;   wq();
    end
    m_sda = 1'b1; wq();
    scl = 1'b1;   wq();
    ack = ~sda_line;
    scl = 1'b0;   wq();
  endtask

  task automatic rd_byte(input logic give_ack, output logic [7:0] b);
    b = '0;
    for (int i = 0; i < 8; i++) begin
      m_sda = 1'b1; wq();
      scl = 1'b1;   wq();
      b = {b[6:0], sda_line};
      scl = 1'b0;   wq();
    end
    m_sda = ~give_ack; wq();
    scl = 1'b1;   wq();
    scl = 1'b0;   wq();
    m_sda = 1'b1;
  endtask

  task automatic t_reset();
    chk("R10 sda released after reset", {7'd0, sda_oe}, 8'h00);
  endtask

  task automatic t_write_burst();
    logic a;
    bus_start();
    wr_byte({DEV, 1'b0}, a); chk("R2 R3 address ack on write", {7'd0, a}, 8'h01);
    wr_byte(8'h10, a);       chk("R4 pointer byte ack", {7'd0, a}, 8'h01);
    wr_byte(8'hA5, a);       chk("R9 data ack 1", {7'd0, a}, 8'h01);
    wr_byte(8'h3C, a);       chk("R9 data ack 2", {7'd0, a}, 8'h01);
    wr_byte(8'h0F, a);       chk("R9 data ack 3", {7'd0, a}, 8'h01);
    bus_stop();
  endtask

  task automatic t_combined_read();
    logic a; logic [7:0] d;
    bus_start();
    wr_byte({DEV, 1'b0}, a);
    wr_byte(8'h10, a);
    bus_start();
    wr_byte({DEV, 1'b1}, a); chk("R3 address ack on read", {7'd0, a}, 8'h01);
    rd_byte(1'b1, d); chk("R7 R8 first byte at pointer", d, 8'hA5);
    rd_byte(1'b1, d); chk("R5 second byte", d, 8'h3C);
    rd_byte(1'b0, d); chk("R5 third byte", d, 8'h0F);
    bus_stop();
  endtask

  task automatic t_wrong_addr();
    logic a; logic [7:0] d;
    bus_start();
    wr_byte({7'h01, 1'b0}, a); chk("R1 late strap value not matched", {7'd0, a}, 8'h00);
    wr_byte(8'h10, a);         chk("R2 no ack after mismatch", {7'd0, a}, 8'h00);
    wr_byte(8'hFF, a);
    bus_stop();
    bus_start();
    wr_byte({DEV, 1'b0}, a);
    wr_byte(8'h10, a);
    bus_start();
    wr_byte({DEV, 1'b1}, a);
    rd_byte(1'b0, d); chk("R2 ignored bytes did not write", d, 8'hA5);
    bus_stop();
  endtask

  task automatic t_stop_clears();
    logic a; logic [7:0] d;
    bus_start();
    wr_byte({DEV, 1'b0}, a); wr_byte(8'h00, a);
    wr_byte(8'h77, a); wr_byte(8'h88, a);
    bus_stop();
    bus_start();
    wr_byte({DEV, 1'b0}, a); wr_byte(8'h20, a); wr_byte(8'h99, a);
    bus_stop();
    bus_start();
    wr_byte({DEV, 1'b1}, a);
    rd_byte(1'b1, d); chk("R6 read after stop starts at reg 0", d, 8'h77);
    rd_byte(1'b0, d); chk("R6 R5 next byte reg 1", d, 8'h88);
    bus_stop();
  endtask

  task automatic t_rs_write();
    logic a; logic [7:0] d;
    bus_start();
    wr_byte({DEV, 1'b0}, a); wr_byte(8'h30, a); wr_byte(8'h11, a);
    bus_start();
    wr_byte({DEV, 1'b0}, a); wr_byte(8'h22, a);
    chk("R7 write after repeated start acked", {7'd0, a}, 8'h01);
    bus_stop();
    bus_start();
    wr_byte({DEV, 1'b0}, a); wr_byte(8'h30, a);
    bus_start();
    wr_byte({DEV, 1'b1}, a);
    rd_byte(1'b1, d); chk("R7 reg 0x30", d, 8'h11);
    rd_byte(1'b0, d); chk("R7 continued write at reg 0x31", d, 8'h22);
    bus_stop();
  endtask

  task automatic t_wrap();
    logic a; logic [7:0] d;
    bus_start();
    wr_byte({DEV, 1'b0}, a); wr_byte(8'hFF, a);
    wr_byte(8'hE1, a); wr_byte(8'hE2, a);
    bus_stop();
    bus_start();
    wr_byte({DEV, 1'b1}, a);
    rd_byte(1'b0, d); chk("R5 wrap stored to reg 0", d, 8'hE2);
    bus_stop();
    bus_start();
    wr_byte({DEV, 1'b0}, a); wr_byte(8'hFF, a);
    bus_start();
    wr_byte({DEV, 1'b1}, a);
    rd_byte(1'b1, d); chk("R5 reg 0xFF", d, 8'hE1);
    rd_byte(1'b0, d); chk("R5 read wraps to reg 0", d, 8'hE2);
    bus_stop();
  endtask

  task automatic t_nack_release();
    logic a; logic [7:0] d; int low = 0;
    bus_start();
    wr_byte({DEV, 1'b1}, a);
    rd_byte(1'b0, d); chk("R8 msb-first read of reg 0", d, 8'hE2);
    for (int i = 0; i < 9; i++) begin
      m_sda = 1'b1; wq();
      scl = 1'b1;   wq();
      if (!sda_line) low++;
      scl = 1'b0;   wq();
    end
    chk("R10 no drive after master nack", low[7:0], 8'h00);
    bus_stop();
    chk("R10 released after stop", {7'd0, sda_oe}, 8'h00);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    strap = 5'b00001;
    repeat (5) @(negedge clk);
    t_reset();
    t_write_burst();
    t_combined_read();
    t_wrong_addr();
    t_stop_clears();
    t_rs_write();
    t_wrap();
    t_nack_release();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule